// File: doc/BRIEF.md
# Interrupt Redirection Controller

The block watches a parameterised set of interrupt input pins and turns their activity into outgoing interrupt messages. Every pin owns a 64-bit redirection entry that selects edge or level behaviour, a mask, the vector to send, a delivery-mode field and a destination that is either a physical target ID or a logical destination set. Software reaches the entries through an indexed 32-bit register port: each entry fills two neighbouring index slots, the low word first.

Per pin, the block keeps a delivery-status flag and a remote-pending flag. An edge pin is locked out from the moment its edge is seen until the outgoing message is accepted. A level pin that has been accepted stays blocked until an end-of-interrupt carrying its vector arrives. Pending requests are served lowest pin first, with one message in flight at a time on a valid/ready handshake.

Top module: `intr_redir_ctrl`

## Requirements
- R1: Entry n is reached with its low word at index BASE_IDX+2n and its high word at BASE_IDX+2n+1. An index outside that range reads 0 and writes to it are ignored.
- R2: After reset every low word reads 0x00010000 (masked, all else 0), every high word reads 0, and no message is valid.
- R3: Low-word layout: bits 7:0 vector, 10:8 delivery mode, 11 destination mode (1 = logical), 12 delivery status (read-only), 14 remote pending (read-only), 15 trigger (1 = level), 16 mask (1 = masked). High-word bits 31:24 hold the destination. All other bits read 0, and writes to them, to bit 12 or to bit 14 are ignored.
- R4: On an unmasked edge-mode pin, a 0-to-1 change between two consecutive clock samples sets delivery status and produces one message carrying the entry's vector, delivery mode, trigger mode and the pin number.
- R5: While delivery status is set, further edges on that pin are ignored. The flag clears when the message is accepted, and a later edge produces a new message.
- R6: An asserted, unmasked level-mode pin whose remote-pending flag is 0 produces a message. Acceptance sets remote pending, and while it is set the asserted pin produces no message.
- R7: An end-of-interrupt clears remote pending only in level-mode entries whose vector equals the end-of-interrupt vector. If the pin is still asserted, a new message follows.
- R8: A masked pin produces no message and keeps no request. Unmasking it after the event delivers nothing.
- R9: In physical mode msg_dest_o is {4'b0000, destination[3:0]}. In logical mode it is the full 8-bit destination. msg_logical_o carries the mode.
- R10: When several pins request at once, the lowest pin number is sent first. Only one message is outstanding.
- R11: While msg_valid_o is high and msg_ready_i is low, all message fields stay stable. A cycle with both high accepts the message, and valid drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_i | input | NUM_PINS | Interrupt input pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_idx_i (combinational) |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted |
| msg_pin_o | output | PIN_W | Source pin of the message |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 8 | Message destination |
| msg_logical_o | output | 1 | Destination mode, 1 = logical |
| msg_level_o | output | 1 | Trigger mode, 1 = level |
| msg_mode_o | output | 3 | Delivery mode field |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | 8 | End-of-interrupt vector |

## Verification
The bench builds the block with its defaults: 24 pins and a base index of 0x10. With these values the last entry sits at slots 0x3E/0x3F and the first unused index is 0x40, so both ends of the index decode are covered. With 24 pins, the requests that compete for the one message slot can lie far apart, which makes the lowest-first ordering visible. The level-mode scenarios drive both a matching and a non-matching end-of-interrupt vector while the pin stays asserted.

// File: rtl/intr_redir_pkg.sv
package intr_redir_pkg;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       level;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } redir_cfg_t;

    localparam redir_cfg_t CFG_RESET = '{
        dest:    8'h00,
        mask:    1'b1,
        level:   1'b0,
        logical: 1'b0,
        mode:    3'h0,
        vector:  8'h00
    };

endpackage

// File: rtl/intr_redir_entries.sv
module intr_redir_entries
    import intr_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned BASE_IDX = 16,
    parameter int unsigned PIN_W    = 5
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PINS-1:0]             pins_i,
    input  logic                            reg_wr_i,
    input  logic [IDX_W-1:0]                reg_idx_i,
    input  logic [31:0]                     reg_wdata_i,
    output logic [31:0]                     reg_rdata_o,
    input  logic                            busy_i,
    input  logic                            accept_i,
    input  logic [PIN_W-1:0]                cur_pin_i,
    input  logic                            eoi_valid_i,
    input  logic [7:0]                      eoi_vector_i,
    output redir_cfg_t [NUM_PINS-1:0]       cfg_o,
    output logic [NUM_PINS-1:0]             pend_o,
    output logic [NUM_PINS-1:0]             rirr_o
);

    localparam int unsigned SPAN = 2 * NUM_PINS;
    localparam int unsigned OFF_W = IDX_W + 1;

    typedef struct packed {
        redir_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]       pend;
        logic [NUM_PINS-1:0]       rirr;
        logic [NUM_PINS-1:0]       prev;
    } ent_state_t;

    ent_state_t st_d, st_q;

    logic [OFF_W-1:0]    off;
    logic                in_rng;
    logic [NUM_PINS-1:0] lo_sel, hi_sel;
    logic [NUM_PINS-1:0] busy_vec, acc_vec, eoi_vec;

    assign off    = {1'b0, reg_idx_i} - OFF_W'(BASE_IDX);
    assign in_rng = ({1'b0, reg_idx_i} >= OFF_W'(BASE_IDX)) && (off < OFF_W'(SPAN));

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            lo_sel[i]   = in_rng && (off == OFF_W'(2 * i));
            hi_sel[i]   = in_rng && (off == OFF_W'(2 * i + 1));
            busy_vec[i] = busy_i && (cur_pin_i == PIN_W'(i));
            acc_vec[i]  = accept_i && (cur_pin_i == PIN_W'(i));
            eoi_vec[i]  = eoi_valid_i && st_q.cfg[i].level &&
                          (st_q.cfg[i].vector == eoi_vector_i);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = pins_i;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (reg_wr_i && lo_sel[i]) begin
                st_d.cfg[i].vector  = reg_wdata_i[7:0];
                st_d.cfg[i].mode    = reg_wdata_i[10:8];
                st_d.cfg[i].logical = reg_wdata_i[11];
                st_d.cfg[i].level   = reg_wdata_i[15];
                st_d.cfg[i].mask    = reg_wdata_i[16];
            end
            if (reg_wr_i && hi_sel[i]) begin
                st_d.cfg[i].dest = reg_wdata_i[31:24];
            end

            if (st_q.cfg[i].level) begin
                if (busy_vec[i]) begin
                    st_d.pend[i] = ~acc_vec[i];
                end else begin
                    st_d.pend[i] = pins_i[i] & ~st_q.cfg[i].mask & ~st_q.rirr[i];
                end
                if (acc_vec[i]) begin
                    st_d.rirr[i] = 1'b1;
                end else if (eoi_vec[i]) begin
                    st_d.rirr[i] = 1'b0;
                end
            end else begin
                st_d.rirr[i] = 1'b0;
                if (acc_vec[i]) begin
                    st_d.pend[i] = 1'b0;
                end else if (st_q.cfg[i].mask && !busy_vec[i]) begin
                    st_d.pend[i] = 1'b0;
                end else if (pins_i[i] && !st_q.prev[i] && !st_q.cfg[i].mask) begin
                    st_d.pend[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.rirr <= '0;
            st_q.prev <= '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                st_q.cfg[i] <= CFG_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (lo_sel[i]) begin
                reg_rdata_o = {15'h0000, st_q.cfg[i].mask, st_q.cfg[i].level,
                               st_q.rirr[i], 1'b0, st_q.pend[i],
                               st_q.cfg[i].logical, st_q.cfg[i].mode,
                               st_q.cfg[i].vector};
            end
            if (hi_sel[i]) begin
                reg_rdata_o = {st_q.cfg[i].dest, 24'h000000};
            end
        end
    end

    assign cfg_o  = st_q.cfg;
    assign pend_o = st_q.pend;
    assign rirr_o = st_q.rirr;

endmodule

// File: rtl/intr_redir_arbiter.sv
module intr_redir_arbiter #(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned PIN_W    = 5
) (
    input  logic [NUM_PINS-1:0] req_i,
    output logic                gnt_valid_o,
    output logic [PIN_W-1:0]    gnt_idx_o
);

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = PIN_W'(i);
            end
        end
    end

endmodule

// File: rtl/intr_redir_ctrl.sv
module intr_redir_ctrl
    import intr_redir_pkg::*;
#(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned BASE_IDX = 16,
    parameter int unsigned PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pins_i,
    input  logic                reg_wr_i,
    input  logic [IDX_W-1:0]    reg_idx_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                msg_valid_o,
    input  logic                msg_ready_i,
    output logic [PIN_W-1:0]    msg_pin_o,
    output logic [7:0]          msg_vector_o,
    output logic [7:0]          msg_dest_o,
    output logic                msg_logical_o,
    output logic                msg_level_o,
    output logic [2:0]          msg_mode_o,
    input  logic                eoi_valid_i,
    input  logic [7:0]          eoi_vector_i
);

    typedef struct packed {
        logic             valid;
        logic [PIN_W-1:0] pin;
        logic [7:0]       vector;
        logic [7:0]       dest;
        logic             logical;
        logic             level;
        logic [2:0]       mode;
    } out_msg_t;

    out_msg_t o_d, o_q;

    redir_cfg_t [NUM_PINS-1:0] cfg_vec;
    logic [NUM_PINS-1:0]       pend_vec, rirr_vec, mask_vec, req_vec;
    logic                      gnt_valid;
    logic [PIN_W-1:0]          gnt_idx;
    logic                      accept;
    redir_cfg_t                sel_cfg;

    assign accept = o_q.valid && msg_ready_i;

    intr_redir_entries #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W),
        .BASE_IDX (BASE_IDX),
        .PIN_W    (PIN_W)
    ) u_entries (
        .clk          (clk),
        .rst_n        (rst_n),
        .pins_i       (irq_pins_i),
        .reg_wr_i     (reg_wr_i),
        .reg_idx_i    (reg_idx_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .busy_i       (o_q.valid),
        .accept_i     (accept),
        .cur_pin_i    (o_q.pin),
        .eoi_valid_i  (eoi_valid_i),
        .eoi_vector_i (eoi_vector_i),
        .cfg_o        (cfg_vec),
        .pend_o       (pend_vec),
        .rirr_o       (rirr_vec)
    );

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            mask_vec[i] = cfg_vec[i].mask;
        end
    end

    assign req_vec = pend_vec & ~mask_vec;

    intr_redir_arbiter #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_arb (
        .req_i       (req_vec),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    assign sel_cfg = cfg_vec[gnt_idx];

    always_comb begin
        o_d = o_q;
        if (accept) begin
            o_d.valid = 1'b0;
        end else if (!o_q.valid && gnt_valid) begin
            o_d.valid   = 1'b1;
            o_d.pin     = gnt_idx;
            o_d.vector  = sel_cfg.vector;
            o_d.dest    = sel_cfg.logical ? sel_cfg.dest : {4'h0, sel_cfg.dest[3:0]};
            o_d.logical = sel_cfg.logical;
            o_d.level   = sel_cfg.level;
            o_d.mode    = sel_cfg.mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign msg_valid_o   = o_q.valid;
    assign msg_pin_o     = o_q.pin;
    assign msg_vector_o  = o_q.vector;
    assign msg_dest_o    = o_q.dest;
    assign msg_logical_o = o_q.logical;
    assign msg_level_o   = o_q.level;
    assign msg_mode_o    = o_q.mode;

endmodule

// File: rtl/intr_redir_ctrl_chk.sv
module intr_redir_ctrl_chk #(
    parameter int unsigned NUM_PINS = 24,
    parameter int unsigned PIN_W    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [PIN_W-1:0]    msg_pin,
    input logic [7:0]          msg_vector,
    input logic [7:0]          msg_dest,
    input logic                msg_logical,
    input logic                msg_level,
    input logic [NUM_PINS-1:0] req_vec,
    input logic [NUM_PINS-1:0] pend_vec,
    input logic [NUM_PINS-1:0] rirr_vec,
    input logic [NUM_PINS-1:0] mask_vec
);

    logic [NUM_PINS-1:0] req_prev, rirr_prev, mask_prev;
    logic [NUM_PINS-1:0] low_mask;

    always_ff @(posedge clk) begin
        req_prev  <= req_vec;
        rirr_prev <= rirr_vec;
        mask_prev <= mask_vec;
    end

    assign low_mask = (NUM_PINS'(1) << msg_pin) - NUM_PINS'(1);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                       $stable(msg_dest) && $stable(msg_pin) &&
                                       $stable(msg_level)));

    a_r11_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);

    a_r9_physical_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_logical) |-> (msg_dest[7:4] == 4'h0));

    a_r8_no_masked_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> !mask_prev[msg_pin]);

    a_r6_remote_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(msg_valid) && msg_level) |-> !rirr_prev[msg_pin]);

    a_r10_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (req_prev[msg_pin] && ((req_prev & low_mask) == '0)));

    a_r4_status_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> pend_vec[msg_pin]);

endmodule

bind intr_redir_ctrl intr_redir_ctrl_chk #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msg_valid   (msg_valid_o),
    .msg_ready   (msg_ready_i),
    .msg_pin     (msg_pin_o),
    .msg_vector  (msg_vector_o),
    .msg_dest    (msg_dest_o),
    .msg_logical (msg_logical_o),
    .msg_level   (msg_level_o),
    .req_vec     (req_vec),
    .pend_vec    (pend_vec),
    .rirr_vec    (rirr_vec),
    .mask_vec    (mask_vec)
);

// File: tb/intr_redir_ctrl_tb_top.sv
`timescale 1ns/1ps
module intr_redir_ctrl_tb_top;

    localparam int NP = 24;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_idx = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [PW-1:0] msg_pin;
    logic [7:0]    msg_vector, msg_dest;
    logic          msg_logical, msg_level;
    logic [2:0]    msg_mode;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intr_redir_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_pins_i    (pins),
        .reg_wr_i      (reg_wr),
        .reg_idx_i     (reg_idx),
        .reg_wdata_i   (reg_wdata),
        .reg_rdata_o   (reg_rdata),
        .msg_valid_o   (msg_valid),
        .msg_ready_i   (msg_ready),
        .msg_pin_o     (msg_pin),
        .msg_vector_o  (msg_vector),
        .msg_dest_o    (msg_dest),
        .msg_logical_o (msg_logical),
        .msg_level_o   (msg_level),
        .msg_mode_o    (msg_mode),
        .eoi_valid_i   (eoi_valid),
        .eoi_vector_i  (eoi_vector)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_idx = idx; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [31:0] data);
        @(negedge clk);
        reg_idx = idx;
        #1;
        data = reg_rdata;
    endtask

    task automatic wait_msg(output bit got);
        got = 1'b0;
        for (int k = 0; k < 8 && !got; k++) begin
            @(negedge clk);
            if (msg_valid) got = 1'b1;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int n);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        check(req, seen, 0);
    endtask

    task automatic set_pin(input int p, input logic v);
        @(negedge clk);
        pins[p] = v;
    endtask

    task automatic send_eoi(input logic [7:0] vec);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = vec;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R2 no message after reset", msg_valid, 0);
        reg_read(8'h10, d); check("R2 entry0 low", d, 32'h0001_0000);
        reg_read(8'h11, d); check("R2 entry0 high", d, 32'h0);
        reg_read(8'h3E, d); check("R1 R2 entry23 low at 3E", d, 32'h0001_0000);
        reg_read(8'h3F, d); check("R1 R2 entry23 high at 3F", d, 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        reg_write(8'h1A, 32'hFFFF_FFFF);
        reg_read(8'h1A, d); check("R3 low writable bits entry5", d, 32'h0001_8FFF);
        reg_write(8'h1B, 32'hFFFF_FFFF);
        reg_read(8'h1B, d); check("R3 high writable bits entry5", d, 32'hFF00_0000);
        reg_write(8'h1A, 32'h0001_0000);
        reg_write(8'h40, 32'hFFFF_FFFF);
        reg_read(8'h40, d); check("R1 index past last entry", d, 32'h0);
        reg_read(8'h0F, d); check("R1 index below base", d, 32'h0);
        reg_read(8'h3E, d); check("R1 last entry unaffected", d, 32'h0001_0000);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        bit got;
        reg_write(8'h17, 32'hA500_0000);
        reg_write(8'h16, 32'h0000_0341);
        set_pin(3, 1'b1);
        wait_msg(got);
        check("R4 edge message appears", got, 1);
        check("R4 pin", msg_pin, 3);
        check("R4 vector", msg_vector, 8'h41);
        check("R4 delivery mode", msg_mode, 3'h3);
        check("R4 trigger edge", msg_level, 0);
        check("R9 physical dest", msg_dest, 8'h05);
        check("R9 logical flag", msg_logical, 0);
        repeat (3) @(negedge clk);
        check("R11 held valid", msg_valid, 1);
        check("R11 held vector", msg_vector, 8'h41);
        reg_read(8'h16, d); check("R4 delivery status set", d, 32'h0000_1341);
        set_pin(3, 1'b0);
        set_pin(3, 1'b1);
        ack();
        check("R11 valid drops after accept", msg_valid, 0);
        expect_quiet("R5 edge during lockout ignored", 6);
        reg_read(8'h16, d); check("R5 status cleared", d, 32'h0000_0341);
        set_pin(3, 1'b0);
        set_pin(3, 1'b1);
        wait_msg(got);
        check("R5 new edge after accept", got, 1);
        ack();
        set_pin(3, 1'b0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        bit got;
        reg_write(8'h1F, 32'hC300_0000);
        reg_write(8'h1E, 32'h0000_8D62);
        set_pin(7, 1'b1);
        wait_msg(got);
        check("R6 level message", got, 1);
        check("R6 pin", msg_pin, 7);
        check("R6 trigger level", msg_level, 1);
        check("R9 logical dest", msg_dest, 8'hC3);
        check("R9 logical flag", msg_logical, 1);
        check("R4 delivery mode carried", msg_mode, 3'h5);
        ack();
        reg_read(8'h1E, d); check("R6 remote pending set", d, 32'h0000_CD62);
        expect_quiet("R6 blocked while remote pending", 6);
        send_eoi(8'h63);
        expect_quiet("R7 wrong vector keeps block", 5);
        reg_read(8'h1E, d); check("R7 remote pending kept", d[14], 1);
        send_eoi(8'h62);
        wait_msg(got);
        check("R7 redelivery after matching eoi", got, 1);
        check("R7 pin", msg_pin, 7);
        @(negedge clk);
        pins[7] = 1'b0;
        ack();
        send_eoi(8'h62);
        expect_quiet("R7 no message after pin dropped", 6);
        reg_read(8'h1E, d); check("R7 remote pending cleared", d, 32'h0000_8D62);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        reg_write(8'h22, 32'h0001_0020);
        set_pin(9, 1'b1);
        expect_quiet("R8 masked edge not delivered", 6);
        reg_read(8'h22, d); check("R8 no status on masked pin", d, 32'h0001_0020);
        reg_write(8'h22, 32'h0000_0020);
        expect_quiet("R8 unmask delivers nothing", 6);
        set_pin(9, 1'b0);
    endtask

    task automatic t_priority();
        bit got;
        reg_write(8'h14, 32'h0000_0051);
        reg_write(8'h28, 32'h0000_0052);
        @(negedge clk);
        pins[2] = 1'b1; pins[12] = 1'b1;
        wait_msg(got);
        check("R10 first message", got, 1);
        check("R10 lowest pin first", msg_pin, 2);
        check("R10 vector of pin 2", msg_vector, 8'h51);
        ack();
        wait_msg(got);
        check("R10 second message", got, 1);
        check("R10 next pin", msg_pin, 12);
        check("R10 vector of pin 12", msg_vector, 8'h52);
        ack();
        expect_quiet("R10 nothing further", 4);
        @(negedge clk);
        pins[2] = 1'b0; pins[12] = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_edge();
        t_level();
        t_mask();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule